// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small Moore controller for a vending slot that takes only nickels (5 cents) and dimes (10 cents). It adds up the coins as they arrive and releases one item once the total reaches 15 cents. It keeps no change: a 20-cent total also gives exactly one release. The credit is held as one of four states: zero, five, ten, and "fifteen or more". Two flip-flops store that state.

The coin sensor drives a one-cycle pulse on `nickel_i` or `dime_i` for each coin it detects. The release output `open_o` is decoded from the registered state alone. It rises on the clock edge that samples the coin bringing the total to 15 cents. It stays high for one cycle while the full state is held.

Top module: `vend_ctrl`

## Requirements
- R1: When `rst_n` is sampled low at a rising clock edge, the credit returns to zero and `open_o` is low after that edge.
- R2: A nickel pulse sampled in a credit state below the price adds one 5-cent step: zero goes to five, five goes to ten, and ten goes to full.
- R3: A dime pulse sampled in a credit state below the price adds two steps. Zero goes to ten. Five or ten goes to full, and any excess over 15 cents is absorbed with no change returned.
- R4: `open_o` is high exactly in the cycles that follow an edge which entered the full state. It depends only on the state, so a coin causes no combinational change of `open_o`.
- R5: In the full state with no coin present, the next edge returns the credit to zero, so a release lasts exactly one cycle.
- R6: If `nickel_i` and `dime_i` are both high in the same cycle, neither coin is counted. A credit state below the price is held, and the full state treats the pair as no coin.
- R7: A single coin sampled in the full state starts the next purchase. A nickel leads to five and a dime leads to ten.
- R8: With no coin present, a credit state below the price is held unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nickel_i | input | 1 | One-cycle pulse per 5-cent coin |
| dime_i | input | 1 | One-cycle pulse per 10-cent coin |
| open_o | output | 1 | Release strobe, high while the full state is held |

## Verification
The assertions assume that each coin arrives as a single pulse sampled at one clock edge. They assume that a held-high input counts again on every edge. They also assume that the two coin lines are either exclusive or deliberately both high, which is the case R6 defines. The scoreboard stimulus changes the coin lines only on falling edges, so every pulse covers exactly one rising edge. It uses the simultaneous-coin case only on purpose, to exercise R6. Every ordering of nickels and dimes that reaches 15 or 20 cents is driven, with and without idle gaps. Some of these orderings are followed by coins during the release cycle.

// File: rtl/vend_pkg.sv
// Package: shared encodings for the vending controller.
// Assumes credit steps are 5 cents and the price is three steps.
package vend_pkg;
    localparam int CREDIT_W   = 2;
    localparam int NICKEL_STP = 1;
    localparam int DIME_STP   = 2;
    localparam int PRICE_STP  = 3;

    // Credit held in 5-cent steps; the top code is "price reached".
    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'd0,
        CR_FIVE = 2'd1,
        CR_TEN  = 2'd2,
        CR_FULL = 2'd3
    } credit_e;

    // Qualified coin event for one cycle.
    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2
    } coin_e;
endpackage

// File: rtl/vend_coin_qual.sv
// Module: turns the two raw coin pulses into one qualified coin event.
// Assumes pulses are already synchronous; a simultaneous pair is dropped.
module vend_coin_qual
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    // Classify the coin lines; both high counts as no coin (R6).
    always_comb begin
        unique case ({dime_i, nickel_i})
            2'b01:   coin_o = COIN_NICKEL;
            2'b10:   coin_o = COIN_DIME;
            default: coin_o = COIN_NONE;
        endcase
    end
endmodule

// File: rtl/vend_next_state.sv
// Module: next-credit logic for the vending controller.
// Adds coin steps with saturation at the price; leaves full state afresh.
module vend_next_state
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  coin_e   coin_i,
    output credit_e nxt_o
);
    localparam int SUM_W = CREDIT_W + 1;

    logic [SUM_W-1:0] steps;
    logic [SUM_W-1:0] sum;

    // Convert the coin event into a step count.
    always_comb begin
        unique case (coin_i)
            COIN_NICKEL: steps = SUM_W'(NICKEL_STP);
            COIN_DIME:   steps = SUM_W'(DIME_STP);
            default:     steps = '0;
        endcase
    end

    // Add to current credit; saturate at the price so overpay is absorbed.
    always_comb begin
        sum = {1'b0, cur_i} + steps;
        if (cur_i == CR_FULL) begin
            nxt_o = credit_e'(steps[CREDIT_W-1:0]);
        end else if (sum >= SUM_W'(PRICE_STP)) begin
            nxt_o = CR_FULL;
        end else begin
            nxt_o = credit_e'(sum[CREDIT_W-1:0]);
        end
    end
endmodule

// File: rtl/vend_state_reg.sv
// Module: the two credit flip-flops with synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  credit_e d_i,
    output credit_e q_o
);
    // Register the next credit, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= CR_ZERO;
        else        q_o <= d_i;
    end

    AST_FULL_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o == CR_FULL) |=> (q_o != CR_FULL)); // R5
endmodule

// File: rtl/vend_ctrl.sv
// Module: top of the coin-accumulating vending controller (Moore).
// Releases one item once 15 cents are credited; no change is given.
// Assumes each coin is a one-cycle pulse synchronous to clk.
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);
    coin_e   coin;
    credit_e credit_q;
    credit_e credit_d;

    vend_coin_qual u_qual (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_next_state u_next (
        .cur_i  (credit_q),
        .coin_i (coin),
        .nxt_o  (credit_d)
    );

    vend_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (credit_d),
        .q_o   (credit_q)
    );

    // Decode the release strobe from the state only.
    always_comb open_o = (credit_q == CR_FULL);

    AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q == CR_ZERO && nickel_i && !dime_i) |=> (credit_q == CR_FIVE)); // R2
    AST_DIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_q == CR_FIVE && dime_i && !nickel_i) |=> open_o); // R3
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> !open_o); // R4
    AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && !nickel_i && !dime_i) |=> (credit_q == CR_ZERO)); // R5
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && nickel_i && dime_i) |=> $stable(credit_q)); // R6
    AST_FULL_DIME: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && dime_i && !nickel_i) |=> (credit_q == CR_TEN)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && !nickel_i && !dime_i) |=> $stable(credit_q)); // R8
endmodule

// File: tb/vend_ctrl_tb.sv
// Scoreboard bench: the driver pushes expected open_o values, the monitor
// pops them one cycle per rising edge and compares.
module vend_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic open_w;

    int checks = 0;
    int errors = 0;
    int credit = 0;          // bench model in cents
    bit    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nickel_i (nickel),
        .dime_i   (dime),
        .open_o   (open_w)
    );

    // Driver step: coin 0 none, 1 nickel, 2 dime, 3 both; rst low resets.
    task automatic step(input int coin, input bit rst, input string tag);
        int val;
        @(negedge clk);
        rst_n  = rst;
        nickel = (coin == 1 || coin == 3);
        dime   = (coin == 2 || coin == 3);
        val = (coin == 1) ? 5 : (coin == 2) ? 10 : 0;
        if (!rst)               credit = 0;
        else if (credit >= 15)  credit = val;
        else                    credit = (credit + val > 15) ? 15 : credit + val;
        exp_q.push_back(credit >= 15);
        tag_q.push_back(tag);
    endtask

    // Monitor: after each rising edge compare open_o with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (open_w !== e) begin
                    errors++;
                    $display("FAIL %s open_o actual=%b expected=%b at %0t", t, open_w, e, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Drive one purchase from zero: coins in order, idle gaps in between.
    task automatic buy(input int c0, input int c1, input int c2, input int gap, input string tag);
        int seq[3];
        seq = '{c0, c1, c2};
        for (int i = 0; i < 3; i++) begin
            if (seq[i] != 0) begin
                step(seq[i], 1'b1, tag);
                for (int g = 0; g < gap; g++) step(0, 1'b1, "R8 idle hold");
            end
        end
        step(0, 1'b1, "R5 release ends");
        step(0, 1'b1, "R5 back at zero");
    endtask

    initial begin
        step(0, 1'b0, "R1 reset");
        step(0, 1'b0, "R1 reset held");
        // Every ordering reaching 15 or 20 cents, back to back then spaced.
        for (int gap = 0; gap < 3; gap++) begin
            buy(1, 1, 1, gap, "R2 nickel-nickel-nickel");
            buy(1, 1, 2, gap, "R3 nickel-nickel-dime overpay");
            buy(1, 2, 0, gap, "R3 nickel-dime");
            buy(2, 1, 0, gap, "R2 dime-nickel");
            buy(2, 2, 0, gap, "R3 dime-dime overpay");
        end
        // R6: both coins together in each credit state below price.
        step(3, 1'b1, "R6 pair at zero");
        step(1, 1'b1, "R6 nickel after pair");
        step(3, 1'b1, "R6 pair at five");
        step(1, 1'b1, "R6 nickel after pair");
        step(3, 1'b1, "R6 pair at ten");
        step(1, 1'b1, "R4 reach price");
        step(3, 1'b1, "R6 pair in full state");
        step(1, 1'b1, "R6 credit zero after pair");
        step(1, 1'b1, "R6 ten");
        step(1, 1'b1, "R4 price");
        // R7: coin during release cycle.
        step(2, 1'b1, "R7 dime in full");
        step(1, 1'b1, "R7 nickel tops up");
        step(1, 1'b1, "R7 nickel in full");
        step(2, 1'b1, "R7 dime tops up");
        step(0, 1'b1, "R5 release ends");
        // R1: reset in the middle of a purchase.
        step(2, 1'b1, "R3 dime");
        step(0, 1'b0, "R1 reset clears credit");
        step(1, 1'b1, "R1 nickel after reset");
        step(1, 1'b1, "R1 ten after reset");
        step(1, 1'b1, "R4 price after reset");
        step(0, 1'b1, "R5 release ends");
        step(0, 1'b1, "R8 idle");
        repeat (3) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard items left actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule